// File: doc/BRIEF.md
# ECC Error Capture Interrupt Unit

This unit sits beside the read path of a memory controller. The ECC logic there reports two kinds of event, correctable (CE) and uncorrectable (UE). Each report carries the failing address, the raw data word, the check syndrome and the ID of the requester that issued the read. The unit keeps one capture set for each class. A capture set stores the details of the first event of its class and holds them until software acknowledges it. Each class also has a two-bit status field. The low bit marks a pending event and the high bit marks an overrun. The unit drives a single level interrupt from the status fields.

Software reaches the unit through a simple 32-bit register port on a 4-byte stride. It enables reporting in a control word and reads the status. It clears status bits by writing ones to an acknowledge word. A mask word holds a bit for the ECC group and a global bit, and either one silences the interrupt.

Top module: `ecc_err_capture`

## Requirements
- R1: After reset, every readable register returns 0 and `irq_o` is low.
- R2: When reporting is enabled and the CE status field is 0, a CE event sets status bit 0 and captures the event. The captures read back at these offsets: the address low word at 0x10; the address bits 33:32 in bits 1:0 of 0x14, with the syndrome in bits 15:8 of 0x14; the data low word at 0x18 and the data high word at 0x1C; the requester ID in bits 29:16 of 0x30.
- R3: When reporting is enabled and the UE status field is 0, a UE event sets status bit 2 and captures the event. The captures read back at these offsets: the address low word at 0x20; the address bits 33:32 in bits 1:0 of 0x24, with the syndrome in bits 15:8 of 0x24; the data low word at 0x28 and the data high word at 0x2C; the requester ID in bits 13:0 of 0x30.
- R4: An event whose class status field is nonzero sets that class's overrun bit (bit 1 for CE, bit 3 for UE) and leaves its capture set unchanged.
- R5: A write to offset 0x08 clears each status bit (read at offset 0x04) whose position is written as 1, and leaves the other bits unchanged. A capture set reloads only after its whole status field is 0.
- R6: A CE and a UE event in the same cycle are both captured, each in its own set.
- R7: Reporting is enabled by bits 17:16 of the control word at 0x00, and one bit set is enough. While both bits are 0, events change neither status nor captures.
- R8: `irq_o` is high exactly when some status bit is set, mask bit 2 (the ECC group) is clear and mask bit 31 (global) is clear. The mask word is at 0x0C, and its other bits have no effect on `irq_o`.
- R9: The control word reads back only bits 17:16, and the mask word reads back all 32 bits. Writes to status, capture and source-ID offsets are ignored. A misaligned access, or one to an unmapped offset, has no effect and reads 0.
- R10: When an acknowledge and an event arrive in the same cycle, the event's effect is decided by the status before the acknowledge, and the acknowledge does not clear the bit that the event sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_valid_i | input | 1 | Correctable event strobe |
| ce_addr_i | input | 34 | Correctable event address |
| ce_data_i | input | 64 | Correctable event data |
| ce_synd_i | input | 8 | Correctable event syndrome |
| ce_src_i | input | 14 | Correctable event requester ID |
| ue_valid_i | input | 1 | Uncorrectable event strobe |
| ue_addr_i | input | 34 | Uncorrectable event address |
| ue_data_i | input | 64 | Uncorrectable event data |
| ue_synd_i | input | 8 | Uncorrectable event syndrome |
| ue_src_i | input | 14 | Uncorrectable event requester ID |
| reg_req_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | Register write when high, read when low |
| reg_addr_i | input | 8 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from the address |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench builds the unit with its default widths: a 34-bit address, 64-bit data, an 8-bit syndrome, a 14-bit requester ID and an 8-bit register address. With these widths the two address bits that spill into the high word are real, both ID fields in the shared source word are filled to their edges, and every capture word has live content. Random events, acknowledges, mask changes and enable changes drive the overrun paths and the collisions between events and acknowledges in the same cycle. A model built from the requirements then checks the captures.

// File: rtl/ecc_cap_pkg.sv
package ecc_cap_pkg;
  timeunit 1ns; timeprecision 1ps;

  localparam int NUM_CLS   = 2;
  localparam int CLS_CE    = 0;
  localparam int CLS_UE    = 1;
  localparam int REG_DW    = 32;

  // register word indices (byte offset / 4)
  localparam int WI_CTRL   = 0;
  localparam int WI_STAT   = 1;
  localparam int WI_ACK    = 2;
  localparam int WI_MASK   = 3;
  localparam int WI_CAP0   = 4;   // CE words 4..7, UE words 8..11
  localparam int CAP_WORDS = 4;
  localparam int WI_SRC    = WI_CAP0 + NUM_CLS * CAP_WORDS;

  // field positions
  localparam int EN_LSB       = 16;
  localparam int EN_W         = 2;
  localparam int MASK_ECC_BIT = 2;
  localparam int MASK_ALL_BIT = 31;
  localparam int SYND_LSB     = 8;
  localparam int SRC_CE_LSB   = 16;
  localparam int SRC_UE_LSB   = 0;

  typedef logic [1:0] stat_t;   // [0] pending, [1] overrun

  localparam stat_t ST_PEND = 2'b01;
  localparam stat_t ST_OVR  = 2'b10;
endpackage

// File: rtl/ecc_cap_slot.sv
module ecc_cap_slot
  import ecc_cap_pkg::*;
#(
  parameter int ADDR_W = 34,
  parameter int DATA_W = 64,
  parameter int SYND_W = 8,
  parameter int SRC_W  = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              evt_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [SYND_W-1:0] synd_i,
  input  logic [SRC_W-1:0]  src_i,
  input  stat_t             ack_i,
  output stat_t             status_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic [SYND_W-1:0] synd_o,
  output logic [SRC_W-1:0]  src_o
);
  timeunit 1ns; timeprecision 1ps;

  stat_t             status_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [SYND_W-1:0] synd_q;
  logic [SRC_W-1:0]  src_q;

  logic  take, empty, load;
  stat_t set_bits;

  assign take     = en_i && evt_i;
  assign empty    = (status_q == '0);
  assign load     = take && empty;
  assign set_bits = take ? (empty ? ST_PEND : ST_OVR) : '0;

  // event set wins over a same-cycle acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~ack_i) | set_bits;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      data_q <= '0;
      synd_q <= '0;
      src_q  <= '0;
    end else if (load) begin
      addr_q <= addr_i;
      data_q <= data_i;
      synd_q <= synd_i;
      src_q  <= src_i;
    end
  end

  assign status_o = status_q;
  assign addr_o   = addr_q;
  assign data_o   = data_q;
  assign synd_o   = synd_q;
  assign src_o    = src_q;

  AST_EVENT_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && evt_i) |=> (status_q != '0)); // R2
  AST_CAPTURE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_q != '0) |=> ($stable(addr_q) && $stable(data_q) && $stable(synd_q) && $stable(src_q))); // R4
  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ack_i == 2'b11) && !(en_i && evt_i)) |=> (status_q == '0)); // R5
  AST_DISABLED_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && (ack_i == '0)) |=> $stable(status_q)); // R7
endmodule

// File: rtl/ecc_cap_regs.sv
module ecc_cap_regs
  import ecc_cap_pkg::*;
#(
  parameter int ADDR_W = 34,
  parameter int DATA_W = 64,
  parameter int SYND_W = 8,
  parameter int SRC_W  = 14,
  parameter int REG_AW = 8
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               req_i,
  input  logic                               we_i,
  input  logic [REG_AW-1:0]                  addr_i,
  input  logic [REG_DW-1:0]                  wdata_i,
  output logic [REG_DW-1:0]                  rdata_o,
  output logic [EN_W-1:0]                    en_o,
  output logic                               grp_mask_o,
  output logic                               glob_mask_o,
  output logic [NUM_CLS-1:0][1:0]            ack_o,
  input  logic [NUM_CLS-1:0][1:0]            status_i,
  input  logic [NUM_CLS-1:0][ADDR_W-1:0]     cap_addr_i,
  input  logic [NUM_CLS-1:0][DATA_W-1:0]     cap_data_i,
  input  logic [NUM_CLS-1:0][SYND_W-1:0]     cap_synd_i,
  input  logic [NUM_CLS-1:0][SRC_W-1:0]      cap_src_i
);
  timeunit 1ns; timeprecision 1ps;

  localparam int WIDX_W    = REG_AW - 2;
  localparam int ADDR_HI_W = ADDR_W - 32;
  localparam logic [WIDX_W-1:0] W_CTRL = WIDX_W'(WI_CTRL);
  localparam logic [WIDX_W-1:0] W_ACK  = WIDX_W'(WI_ACK);
  localparam logic [WIDX_W-1:0] W_STAT = WIDX_W'(WI_STAT);
  localparam logic [WIDX_W-1:0] W_MASK = WIDX_W'(WI_MASK);
  localparam logic [WIDX_W-1:0] W_CAP0 = WIDX_W'(WI_CAP0);
  localparam logic [WIDX_W-1:0] W_SRC  = WIDX_W'(WI_SRC);

  logic [WIDX_W-1:0] widx;
  logic              aligned, wr_en, rd_en;
  logic [EN_W-1:0]   en_q;
  logic [REG_DW-1:0] mask_q;
  logic [REG_DW-1:0] cap_word [NUM_CLS][CAP_WORDS];
  logic [2:0]        cofs;

  assign widx    = addr_i[REG_AW-1:2];
  assign aligned = (addr_i[1:0] == 2'b00);
  assign wr_en   = req_i && we_i && aligned;
  assign rd_en   = req_i && !we_i && aligned;
  assign cofs    = 3'(widx - W_CAP0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      mask_q <= '0;
    end else if (wr_en) begin
      if (widx == W_CTRL) en_q   <= wdata_i[EN_LSB +: EN_W];
      if (widx == W_MASK) mask_q <= wdata_i;
    end
  end

  // write-one-to-clear pulses, one field per class
  for (genvar g = 0; g < NUM_CLS; g++) begin : g_ack
    assign ack_o[g] = (wr_en && (widx == W_ACK)) ? wdata_i[2*g +: 2] : 2'b00;
  end

  always_comb begin
    for (int c = 0; c < NUM_CLS; c++) begin
      logic [63:0] dpad;
      dpad = '0;
      dpad[DATA_W-1:0] = cap_data_i[c];
      cap_word[c][0] = cap_addr_i[c][31:0];
      cap_word[c][1] = '0;
      cap_word[c][1][ADDR_HI_W-1:0]    = cap_addr_i[c][ADDR_W-1:32];
      cap_word[c][1][SYND_LSB +: SYND_W] = cap_synd_i[c];
      cap_word[c][2] = dpad[31:0];
      cap_word[c][3] = dpad[63:32];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_en) begin
      if (widx == W_CTRL) begin
        rdata_o[EN_LSB +: EN_W] = en_q;
      end else if (widx == W_STAT) begin
        for (int c = 0; c < NUM_CLS; c++) rdata_o[2*c +: 2] = status_i[c];
      end else if (widx == W_MASK) begin
        rdata_o = mask_q;
      end else if (widx == W_SRC) begin
        rdata_o[SRC_CE_LSB +: SRC_W] = cap_src_i[CLS_CE];
        rdata_o[SRC_UE_LSB +: SRC_W] = cap_src_i[CLS_UE];
      end else if ((widx >= W_CAP0) && (widx < W_SRC)) begin
        rdata_o = cap_word[cofs[2]][cofs[1:0]];
      end
    end
  end

  assign en_o        = en_q;
  assign grp_mask_o  = mask_q[MASK_ECC_BIT];
  assign glob_mask_o = mask_q[MASK_ALL_BIT];

  AST_CTRL_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en && (widx == W_CTRL)) |=> $stable(en_q)); // R9
  AST_MASK_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en && (widx == W_MASK)) |=> $stable(mask_q)); // R9
endmodule

// File: rtl/ecc_cap_irq.sv
module ecc_cap_irq
  import ecc_cap_pkg::*;
(
  input  logic [NUM_CLS-1:0][1:0] status_i,
  input  logic                    grp_mask_i,
  input  logic                    glob_mask_i,
  output logic                    irq_o
);
  timeunit 1ns; timeprecision 1ps;

  logic any_set;

  always_comb begin
    any_set = 1'b0;
    for (int c = 0; c < NUM_CLS; c++) any_set = any_set | (|status_i[c]);
  end

  assign irq_o = any_set && !grp_mask_i && !glob_mask_i;
endmodule

// File: rtl/ecc_err_capture.sv
module ecc_err_capture
  import ecc_cap_pkg::*;
#(
  parameter int ADDR_W = 34,
  parameter int DATA_W = 64,
  parameter int SYND_W = 8,
  parameter int SRC_W  = 14,
  parameter int REG_AW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_valid_i,
  input  logic [ADDR_W-1:0] ce_addr_i,
  input  logic [DATA_W-1:0] ce_data_i,
  input  logic [SYND_W-1:0] ce_synd_i,
  input  logic [SRC_W-1:0]  ce_src_i,
  input  logic              ue_valid_i,
  input  logic [ADDR_W-1:0] ue_addr_i,
  input  logic [DATA_W-1:0] ue_data_i,
  input  logic [SYND_W-1:0] ue_synd_i,
  input  logic [SRC_W-1:0]  ue_src_i,
  input  logic              reg_req_i,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              irq_o
);
  timeunit 1ns; timeprecision 1ps;

  logic [NUM_CLS-1:0]             evt;
  logic [NUM_CLS-1:0][ADDR_W-1:0] ev_addr, cap_addr;
  logic [NUM_CLS-1:0][DATA_W-1:0] ev_data, cap_data;
  logic [NUM_CLS-1:0][SYND_W-1:0] ev_synd, cap_synd;
  logic [NUM_CLS-1:0][SRC_W-1:0]  ev_src,  cap_src;
  logic [NUM_CLS-1:0][1:0]        status, ack;
  logic [EN_W-1:0]                en_field;
  logic                           rpt_en, grp_mask, glob_mask;

  assign evt[CLS_CE]     = ce_valid_i;
  assign ev_addr[CLS_CE] = ce_addr_i;
  assign ev_data[CLS_CE] = ce_data_i;
  assign ev_synd[CLS_CE] = ce_synd_i;
  assign ev_src[CLS_CE]  = ce_src_i;
  assign evt[CLS_UE]     = ue_valid_i;
  assign ev_addr[CLS_UE] = ue_addr_i;
  assign ev_data[CLS_UE] = ue_data_i;
  assign ev_synd[CLS_UE] = ue_synd_i;
  assign ev_src[CLS_UE]  = ue_src_i;

  assign rpt_en = |en_field;

  for (genvar g = 0; g < NUM_CLS; g++) begin : g_slot
    ecc_cap_slot #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYND_W(SYND_W), .SRC_W(SRC_W)
    ) u_slot (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (rpt_en),
      .evt_i   (evt[g]),
      .addr_i  (ev_addr[g]),
      .data_i  (ev_data[g]),
      .synd_i  (ev_synd[g]),
      .src_i   (ev_src[g]),
      .ack_i   (ack[g]),
      .status_o(status[g]),
      .addr_o  (cap_addr[g]),
      .data_o  (cap_data[g]),
      .synd_o  (cap_synd[g]),
      .src_o   (cap_src[g])
    );
  end

  ecc_cap_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYND_W(SYND_W), .SRC_W(SRC_W), .REG_AW(REG_AW)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (reg_req_i),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .rdata_o    (reg_rdata_o),
    .en_o       (en_field),
    .grp_mask_o (grp_mask),
    .glob_mask_o(glob_mask),
    .ack_o      (ack),
    .status_i   (status),
    .cap_addr_i (cap_addr),
    .cap_data_i (cap_data),
    .cap_synd_i (cap_synd),
    .cap_src_i  (cap_src)
  );

  ecc_cap_irq u_irq (
    .status_i   (status),
    .grp_mask_i (grp_mask),
    .glob_mask_i(glob_mask),
    .irq_o      (irq_o)
  );

  AST_BOTH_CAPTURED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rpt_en && ce_valid_i && ue_valid_i) |=> ((status[CLS_CE] != '0) && (status[CLS_UE] != '0))); // R6
  AST_IRQ_FOLLOWS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rpt_en && ce_valid_i && !grp_mask && !glob_mask && !(reg_req_i && reg_we_i)) |=> irq_o); // R8
endmodule

// File: tb/ecc_err_capture_tb_top.sv
module ecc_err_capture_tb_top;
  timeunit 1ns; timeprecision 1ps;

  localparam int CYCLE_LIMIT = 150000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ce_valid_i = 1'b0, ue_valid_i = 1'b0;
  logic [33:0] ce_addr_i = '0, ue_addr_i = '0;
  logic [63:0] ce_data_i = '0, ue_data_i = '0;
  logic [7:0]  ce_synd_i = '0, ue_synd_i = '0;
  logic [13:0] ce_src_i = '0, ue_src_i = '0;
  logic        reg_req_i = 1'b0, reg_we_i = 1'b0;
  logic [7:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        irq_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // model
  logic [1:0]  m_en;
  logic [31:0] m_mask;
  logic [1:0]  m_st   [2];
  logic [33:0] m_addr [2];
  logic [63:0] m_data [2];
  logic [7:0]  m_synd [2];
  logic [13:0] m_src  [2];

  always #5 clk_i = ~clk_i;

  ecc_err_capture dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .ce_valid_i(ce_valid_i), .ce_addr_i(ce_addr_i), .ce_data_i(ce_data_i),
    .ce_synd_i(ce_synd_i), .ce_src_i(ce_src_i),
    .ue_valid_i(ue_valid_i), .ue_addr_i(ue_addr_i), .ue_data_i(ue_data_i),
    .ue_synd_i(ue_synd_i), .ue_src_i(ue_src_i),
    .reg_req_i(reg_req_i), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
  );

  function automatic logic [31:0] exp_word(logic [7:0] a);
    logic [31:0] w;
    int c;
    int k;
    w = '0;
    if (a[1:0] != 2'b00) return '0;
    case (int'(a[7:2]))
      0: w[17:16] = m_en;
      1: w = {28'd0, m_st[1], m_st[0]};
      3: w = m_mask;
      12: w = {2'b00, m_src[0], 2'b00, m_src[1]};
      4, 5, 6, 7, 8, 9, 10, 11: begin
        c = (int'(a[7:2]) - 4) / 4;
        k = (int'(a[7:2]) - 4) % 4;
        case (k)
          0: w = m_addr[c][31:0];
          1: w = {16'd0, m_synd[c], 6'd0, m_addr[c][33:32]};
          2: w = m_data[c][31:0];
          default: w = m_data[c][63:32];
        endcase
      end
      default: w = '0;
    endcase
    return w;
  endfunction

  function automatic logic exp_irq();
    return ((m_st[0] != 0) || (m_st[1] != 0)) && !m_mask[2] && !m_mask[31];
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_en = '0; m_mask = '0;
    for (int c = 0; c < 2; c++) begin
      m_st[c] = '0; m_addr[c] = '0; m_data[c] = '0; m_synd[c] = '0; m_src[c] = '0;
    end
  endtask

  task automatic rand_payload();
    ce_addr_i = {$urandom, $urandom} & 34'h3_FFFF_FFFF;
    ue_addr_i = {$urandom, $urandom} & 34'h3_FFFF_FFFF;
    ce_data_i = {$urandom, $urandom};
    ue_data_i = {$urandom, $urandom};
    ce_synd_i = 8'($urandom);
    ue_synd_i = 8'($urandom);
    ce_src_i  = 14'($urandom);
    ue_src_i  = 14'($urandom);
  endtask

  // one cycle with optional events and optional acknowledge write
  task automatic drive_cycle(bit ce_v, bit ue_v, bit ack_we, logic [3:0] ack_val);
    @(negedge clk_i);
    ce_valid_i = ce_v; ue_valid_i = ue_v;
    reg_req_i = ack_we; reg_we_i = 1'b1; reg_addr_i = 8'h08; reg_wdata_i = {28'd0, ack_val};
    @(posedge clk_i);
    for (int c = 0; c < 2; c++) begin
      bit v;
      logic [1:0] f, nb, a;
      v  = (c == 0) ? ce_v : ue_v;
      v  = v && (m_en != 0);
      f  = m_st[c];
      nb = v ? ((f == 0) ? 2'b01 : 2'b10) : 2'b00;
      if (v && f == 0) begin
        m_addr[c] = (c == 0) ? ce_addr_i : ue_addr_i;
        m_data[c] = (c == 0) ? ce_data_i : ue_data_i;
        m_synd[c] = (c == 0) ? ce_synd_i : ue_synd_i;
        m_src[c]  = (c == 0) ? ce_src_i  : ue_src_i;
      end
      a = ack_we ? ack_val[2*c +: 2] : 2'b00;
      m_st[c] = (f & ~a) | nb;
    end
    #1;
    ce_valid_i = 1'b0; ue_valid_i = 1'b0; reg_req_i = 1'b0; reg_we_i = 1'b0;
  endtask

  task automatic reg_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk_i);
    reg_req_i = 1'b1; reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(posedge clk_i);
    if (a == 8'h00) m_en = d[17:16];
    if (a == 8'h0C) m_mask = d;
    if (a == 8'h08) for (int c = 0; c < 2; c++) m_st[c] = m_st[c] & ~d[2*c +: 2];
    #1;
    reg_req_i = 1'b0; reg_we_i = 1'b0;
  endtask

  task automatic reg_check(string tag, logic [7:0] a);
    @(negedge clk_i);
    reg_req_i = 1'b1; reg_we_i = 1'b0; reg_addr_i = a;
    #1;
    chk(tag, reg_rdata_o, exp_word(a));
    reg_req_i = 1'b0;
  endtask

  task automatic irq_check(string tag);
    @(negedge clk_i);
    #1;
    chk(tag, {31'd0, irq_o}, {31'd0, exp_irq()});
  endtask

  task automatic check_all(string tag);
    reg_check(tag, 8'h00);
    reg_check(tag, 8'h04);
    reg_check(tag, 8'h0C);
    for (int i = 0; i < 8; i++) reg_check(tag, 8'(8'h10 + 4 * i));
    reg_check(tag, 8'h30);
    irq_check(tag);
  endtask

  initial begin
    #(CYCLE_LIMIT * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    model_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    check_all("R1");

    rand_payload();
    drive_cycle(1, 1, 0, 4'h0);
    check_all("R7");

    reg_write(8'h00, 32'h0001_0000);
    reg_check("R7", 8'h00);
    reg_write(8'h00, 32'hFFFF_FFFF);
    reg_check("R9", 8'h00);

    ce_addr_i = 34'h3_DEAD_BEEF; ce_data_i = 64'h0123_4567_89AB_CDEF;
    ce_synd_i = 8'hA5; ce_src_i = 14'h3FFF;
    drive_cycle(1, 0, 0, 4'h0);
    check_all("R2");

    rand_payload();
    drive_cycle(1, 0, 0, 4'h0);
    check_all("R4");

    drive_cycle(0, 0, 1, 4'h1);
    check_all("R5");
    rand_payload();
    drive_cycle(1, 0, 0, 4'h0);
    check_all("R5");
    drive_cycle(0, 0, 1, 4'h2);
    rand_payload();
    drive_cycle(1, 0, 0, 4'h0);
    check_all("R5");

    ue_addr_i = 34'h1_0000_0001; ue_data_i = 64'hFEDC_BA98_7654_3210;
    ue_synd_i = 8'h03; ue_src_i = 14'h2AAA;
    drive_cycle(0, 1, 0, 4'h0);
    check_all("R3");
    rand_payload();
    drive_cycle(0, 1, 0, 4'h0);
    check_all("R4");

    drive_cycle(0, 0, 1, 4'hF);
    rand_payload();
    drive_cycle(1, 1, 0, 4'h0);
    check_all("R6");

    rand_payload();
    drive_cycle(1, 0, 1, 4'h1);
    check_all("R10");

    reg_write(8'h0C, 32'h0000_0004);
    irq_check("R8");
    reg_write(8'h0C, 32'h8000_0000);
    irq_check("R8");
    reg_write(8'h0C, 32'h7FFF_FFFB);
    irq_check("R8");
    reg_check("R9", 8'h0C);
    reg_write(8'h0C, 32'h0000_0000);

    reg_write(8'h04, 32'hFFFF_FFFF);
    reg_write(8'h10, 32'h1234_5678);
    reg_write(8'h2C, 32'hFFFF_FFFF);
    reg_write(8'h30, 32'hFFFF_FFFF);
    reg_write(8'h01, 32'h0000_0000);
    reg_write(8'h09, 32'h0000_000F);
    check_all("R9");
    reg_check("R9", 8'h34);
    reg_check("R9", 8'h11);
    reg_check("R9", 8'hFC);

    reg_write(8'h00, 32'h0000_0000);
    rand_payload();
    drive_cycle(1, 1, 0, 4'h0);
    check_all("R7");
    reg_write(8'h00, 32'h0002_0000);
    drive_cycle(0, 0, 1, 4'hF);
    irq_check("R8");

    for (int it = 0; it < 600; it++) begin
      int op;
      op = int'($urandom % 8);
      rand_payload();
      case (op)
        0, 1: drive_cycle(1, 0, 0, 4'h0);
        2:    drive_cycle(0, 1, 0, 4'h0);
        3:    drive_cycle(1, 1, 0, 4'h0);
        4:    drive_cycle(bit'($urandom), bit'($urandom), 1, 4'($urandom));
        5: begin
          int s;
          s = int'($urandom % 4);
          reg_write(8'h0C, (s == 0) ? 32'h0 : (s == 1) ? 32'h4 : (s == 2) ? 32'h8000_0000
                                     : ($urandom & 32'h7FFF_FFFB));
        end
        6: reg_write(8'h00, ($urandom % 4 == 0) ? 32'h0 : $urandom);
        default: drive_cycle(0, 0, 0, 4'h0);
      endcase
      reg_check("R2/R3/R4/R5/R10", 8'h04);
      irq_check("R8");
      if (it % 4 == 0) check_all("R2/R3/R6");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule